// File: doc/BRIEF.md
# Wavetable Sample Memory Arbiter

This block holds the sample memory of a wavetable sound channel: sixteen bytes, each carrying two four-bit samples, thirty-two samples in all. Two users share it. The processor reaches it through a byte port with an offset, read and write strobes and write data. The playback sequencer presents a five-bit sample index and a one-cycle "fetch window" flag, and takes back the selected sample on a combinational path.

While the channel is idle, the processor sees the memory as plain bytes at its offset. While the channel plays, the processor offset is ignored. Every access is steered to the byte under the playback pointer. A compatibility select picks one of two behaviours during play. The enhanced model always lets the steered access through. The legacy model lets it through only in the cycle the fetch window flag is high. Outside that cycle, reads return all ones and writes are dropped. The playback read path never waits on the processor.

Top module: `wave_ram_arbiter`

## Requirements
- R1: While reset (rst_n low, synchronous) is applied, every memory byte becomes 0x00 and cpu_rdata becomes 0x00.
- R2: With playing low, a write stores cpu_wdata at byte cpu_addr, and a read loads byte cpu_addr into cpu_rdata at the next rising edge.
- R3: With playing high and legacy_mode low, reads and writes use byte play_idx[4:1] whatever cpu_addr holds.
- R4: With playing, legacy_mode and play_window all high, reads and writes use byte play_idx[4:1] whatever cpu_addr holds.
- R5: With playing and legacy_mode high and play_window low, a read loads 0xFF into cpu_rdata.
- R6: With playing and legacy_mode high and play_window low, a write changes no memory byte.
- R7: play_sample is combinational: bits [7:4] of byte play_idx[4:1] when play_idx[0] is 0, and bits [3:0] of it when play_idx[0] is 1. So the high nibble is the earlier sample.
- R8: When cpu_rd is low, cpu_rdata keeps its value.
- R9: When cpu_rd and cpu_wr are both high in one cycle on the same byte, cpu_rdata receives the byte as it was before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| legacy_mode | input | 1 | 1 selects the windowed legacy access model |
| playing | input | 1 | Channel is playing |
| play_idx | input | 5 | Current sample index of the playback pointer |
| play_window | input | 1 | One-cycle flag: playback fetches a byte this cycle |
| play_sample | output | 4 | Sample at play_idx (combinational) |
| cpu_addr | input | 4 | Processor byte offset |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Registered processor read data |

## Verification
On every cycle the checks cover four behaviours. A blocked legacy read must yield 0xFF, and a blocked write must leave the sample under a steady pointer untouched. A granted write during play must appear at once in play_sample when the pointer holds still. cpu_rdata must hold whenever no read is strobed. Other behaviours can only be shown by the bench's reference model across its scenarios: that steering ignores cpu_addr, that idle offsets map to the right bytes, that nibbles come out in order over all thirty-two indices, that read-before-write holds in a shared cycle, and that reset clears memory.

// File: rtl/wave_arb_pkg.sv
// Package: shared constants and the access-path type for the wave memory arbiter.
// Assumes byte-wide processor data.
package wave_arb_pkg;

    // Value returned to the processor for an access that is locked out.
    localparam logic [7:0] LOCKED_READ_VALUE = 8'hFF;

    // Which way a processor access is routed in the current cycle.
    typedef enum logic [1:0] {
        PATH_DIRECT  = 2'd0,  // channel idle: use the processor offset
        PATH_STEERED = 2'd1,  // channel playing: use the playback byte
        PATH_LOCKED  = 2'd2   // legacy play outside the fetch window
    } path_e;

endpackage

// File: rtl/wave_arb_route.sv
// Module: wave_arb_route
// Decides where a processor access goes and whether it is allowed.
// Assumes play_idx packs the byte address above SUB_W sample-select bits.
module wave_arb_route
    import wave_arb_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int SUB_W  = 1,
    localparam int IDX_W = ADDR_W + SUB_W
) (
    input  logic              playing,
    input  logic              legacy_mode,
    input  logic              play_window,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [IDX_W-1:0]  play_idx,
    output path_e             path,
    output logic [ADDR_W-1:0] target_addr
);

    logic [ADDR_W-1:0] play_byte;

    // Byte currently under the playback pointer.
    assign play_byte = play_idx[IDX_W-1:SUB_W];

    // Classify the access by channel state and compatibility model.
    always_comb begin
        if (!playing) begin
            path = PATH_DIRECT;
        end else if (legacy_mode && !play_window) begin
            path = PATH_LOCKED;
        end else begin
            path = PATH_STEERED;
        end
    end

    // Pick the byte address that the access uses.
    always_comb begin
        target_addr = (path == PATH_DIRECT) ? cpu_addr : play_byte;
    end

endmodule

// File: rtl/wave_arb_store.sv
// Module: wave_arb_store
// Register-based byte storage with one write port and two combinational read ports.
// Assumes at most one write per cycle; reads see the pre-write contents.
module wave_arb_store #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr_a,
    output logic [DATA_W-1:0] rd_data_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    output logic [DATA_W-1:0] rd_data_b
);

    logic [DATA_W-1:0] cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        // Hold one byte; clear on reset, load when addressed by a write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cells[g] <= '0;
            end else if (wr_en && (wr_addr == ADDR_W'(g))) begin
                cells[g] <= wr_data;
            end
        end
    end

    // Processor-side read port.
    assign rd_data_a = cells[rd_addr_a];

    // Playback-side read port.
    assign rd_data_b = cells[rd_addr_b];

endmodule

// File: rtl/wave_arb_unpack.sv
// Module: wave_arb_unpack
// Picks one sample out of a packed byte; the most significant sample comes first.
// Assumes DATA_W is a whole multiple of SAMPLE_W.
module wave_arb_unpack #(
    parameter int DATA_W   = 8,
    parameter int SAMPLE_W = 4,
    localparam int PER_BYTE = DATA_W / SAMPLE_W,
    localparam int SUB_W    = $clog2(PER_BYTE)
) (
    input  logic [DATA_W-1:0]   byte_in,
    input  logic [SUB_W-1:0]    sub_idx,
    output logic [SAMPLE_W-1:0] sample
);

    // Select the slot given by sub_idx, slot 0 at the top of the byte.
    always_comb begin
        sample = '0;
        for (int k = 0; k < PER_BYTE; k++) begin
            if (sub_idx == SUB_W'(k)) begin
                sample = byte_in[DATA_W-1-k*SAMPLE_W -: SAMPLE_W];
            end
        end
    end

endmodule

// File: rtl/wave_ram_arbiter.sv
// Module: wave_ram_arbiter (top)
// Shares the wavetable sample memory between the processor byte port and the
// playback sequencer. Playback reads are combinational and always served;
// processor accesses are steered or locked out while the channel plays.
// Assumes play_window is a one-cycle pulse issued by the sequencer at each fetch.
module wave_ram_arbiter
    import wave_arb_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int DATA_W   = 8,
    parameter int SAMPLE_W = 4,
    localparam int ADDR_W   = $clog2(DEPTH),
    localparam int SUB_W    = $clog2(DATA_W / SAMPLE_W),
    localparam int IDX_W    = ADDR_W + SUB_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                legacy_mode,
    input  logic                playing,
    input  logic [IDX_W-1:0]    play_idx,
    input  logic                play_window,
    output logic [SAMPLE_W-1:0] play_sample,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic                cpu_rd,
    input  logic                cpu_wr,
    input  logic [DATA_W-1:0]   cpu_wdata,
    output logic [DATA_W-1:0]   cpu_rdata
);

    path_e             path;
    logic [ADDR_W-1:0] target_addr;
    logic [DATA_W-1:0] cpu_byte;
    logic [DATA_W-1:0] play_byte;
    logic              wr_grant;
    logic [DATA_W-1:0] rdata_q;

    wave_arb_route #(
        .ADDR_W (ADDR_W),
        .SUB_W  (SUB_W)
    ) u_route (
        .playing     (playing),
        .legacy_mode (legacy_mode),
        .play_window (play_window),
        .cpu_addr    (cpu_addr),
        .play_idx    (play_idx),
        .path        (path),
        .target_addr (target_addr)
    );

    // A write lands unless the legacy lock-out applies.
    assign wr_grant = cpu_wr && (path != PATH_LOCKED);

    wave_arb_store #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_grant),
        .wr_addr   (target_addr),
        .wr_data   (cpu_wdata),
        .rd_addr_a (target_addr),
        .rd_data_a (cpu_byte),
        .rd_addr_b (play_idx[IDX_W-1:SUB_W]),
        .rd_data_b (play_byte)
    );

    wave_arb_unpack #(
        .DATA_W   (DATA_W),
        .SAMPLE_W (SAMPLE_W)
    ) u_unpack (
        .byte_in (play_byte),
        .sub_idx (play_idx[SUB_W-1:0]),
        .sample  (play_sample)
    );

    // Capture processor read data on a read strobe; locked reads give all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (cpu_rd) begin
            rdata_q <= (path == PATH_LOCKED) ? DATA_W'(LOCKED_READ_VALUE) : cpu_byte;
        end
    end

    assign cpu_rdata = rdata_q;

endmodule

// File: rtl/wave_ram_arbiter_chk.sv
// Module: wave_ram_arbiter_chk
// Port-level temporal checks for wave_ram_arbiter, attached by bind.
// Assumes two samples per byte (sample select is play_idx[0]).
module wave_ram_arbiter_chk #(
    parameter int IDX_W    = 5,
    parameter int DATA_W   = 8,
    parameter int SAMPLE_W = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                legacy_mode,
    input logic                playing,
    input logic [IDX_W-1:0]    play_idx,
    input logic                play_window,
    input logic [SAMPLE_W-1:0] play_sample,
    input logic                cpu_rd,
    input logic                cpu_wr,
    input logic [DATA_W-1:0]   cpu_wdata,
    input logic [DATA_W-1:0]   cpu_rdata
);

    // R5
    locked_read_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (playing && legacy_mode && !play_window && cpu_rd) |=> (cpu_rdata == 8'hFF));

    // R6
    locked_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (playing && legacy_mode && !play_window && cpu_wr)
        |=> (!$stable(play_idx) || $stable(play_sample)));

    // R3
    enhanced_write_steered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (playing && !legacy_mode && cpu_wr)
        |=> (!$stable(play_idx) || (play_sample == (play_idx[0] ?
            $past(cpu_wdata[SAMPLE_W-1:0]) : $past(cpu_wdata[DATA_W-1:SAMPLE_W])))));

    // R4
    window_write_steered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (playing && legacy_mode && play_window && cpu_wr)
        |=> (!$stable(play_idx) || (play_sample == (play_idx[0] ?
            $past(cpu_wdata[SAMPLE_W-1:0]) : $past(cpu_wdata[DATA_W-1:SAMPLE_W])))));

    // R8
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rd |=> $stable(cpu_rdata));

endmodule

bind wave_ram_arbiter wave_ram_arbiter_chk #(
    .IDX_W    (IDX_W),
    .DATA_W   (DATA_W),
    .SAMPLE_W (SAMPLE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .legacy_mode (legacy_mode),
    .playing     (playing),
    .play_idx    (play_idx),
    .play_window (play_window),
    .play_sample (play_sample),
    .cpu_rd      (cpu_rd),
    .cpu_wr      (cpu_wr),
    .cpu_wdata   (cpu_wdata),
    .cpu_rdata   (cpu_rdata)
);

// File: tb/wave_ram_arbiter_tb.sv
// Bench: behavioural reference model of the wave memory, compared every cycle.
module wave_ram_arbiter_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       legacy_mode = 1'b0;
    logic       playing = 1'b0;
    logic [4:0] play_idx = '0;
    logic       play_window = 1'b0;
    logic [3:0] play_sample;
    logic [3:0] cpu_addr = '0;
    logic       cpu_rd = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;

    int checks = 0;
    int errors = 0;

    int ref_mem [16];
    int ref_rdata = 0;

    always #4 clk = ~clk;

    wave_ram_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .legacy_mode(legacy_mode), .playing(playing),
        .play_idx(play_idx), .play_window(play_window), .play_sample(play_sample),
        .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata)
    );

    function automatic int exp_sample();
        int b = ref_mem[int'(play_idx) / 2];
        return (play_idx[0] == 1'b0) ? (b / 16) : (b % 16);
    endfunction

    task automatic compare(string req);
        checks++;
        if (int'(cpu_rdata) != ref_rdata) begin
            errors++;
            $display("FAIL %s cpu_rdata actual %02h expected %02h", req, cpu_rdata, ref_rdata);
        end
        checks++;
        if (int'(play_sample) != exp_sample()) begin
            errors++;
            $display("FAIL %s play_sample idx %0d actual %0h expected %0h",
                     req, play_idx, play_sample, exp_sample());
        end
    endtask

    // One clock: drive at negedge, advance model at posedge, compare at next negedge.
    task automatic step(string req, bit pl, bit leg, bit win, int idx,
                        int addr, bit rd, bit wr, int wdata);
        int tgt;
        bit ok;
        playing = pl; legacy_mode = leg; play_window = win;
        play_idx = 5'(idx); cpu_addr = 4'(addr); cpu_rd = rd; cpu_wr = wr;
        cpu_wdata = 8'(wdata);
        @(posedge clk);
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) ref_mem[i] = 0;
            ref_rdata = 0;
        end else begin
            tgt = pl ? idx / 2 : addr;
            ok  = !pl || !leg || win;
            if (rd) ref_rdata = ok ? ref_mem[tgt] : 8'hFF;
            if (wr && ok) ref_mem[tgt] = wdata & 8'hFF;
        end
        @(negedge clk);
        compare(req);
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) ref_mem[i] = 0;
        @(negedge clk);
        // R1: scribble something, then reset clears memory and read data.
        rst_n = 1'b1;
        step("R2", 0, 0, 0, 0, 3, 0, 1, 8'h9C);
        step("R2", 0, 0, 0, 0, 3, 1, 0, 0);
        rst_n = 1'b0;
        step("R1", 0, 0, 0, 6, 3, 0, 0, 0);
        step("R1", 0, 0, 0, 7, 3, 0, 0, 0);
        rst_n = 1'b1;
        step("R1", 0, 0, 0, 6, 3, 1, 0, 0);

        // R2: idle fill all bytes at their offsets, then read each back.
        for (int a = 0; a < 16; a++) step("R2", 0, 0, 0, 0, a, 0, 1, (a * 37 + 5) ^ 8'hA5);
        for (int a = 15; a >= 0; a--) step("R2", 0, 0, 0, 0, a, 1, 0, 0);

        // R7: sweep every sample index, both compatibility settings.
        for (int i = 0; i < 32; i++) step("R7", 0, 0, 0, i, 0, 0, 0, 0);
        for (int i = 31; i >= 0; i--) step("R7", 1, 1, 0, i, 0, 0, 0, 0);

        // R3: enhanced play steers writes and reads, ignoring cpu_addr.
        step("R3", 1, 0, 0, 9, 0, 0, 1, 8'h3E);
        step("R3", 1, 0, 0, 9, 15, 1, 0, 0);
        step("R3", 1, 0, 0, 20, 1, 1, 1, 8'hD7);
        step("R3", 0, 0, 0, 0, 10, 1, 0, 0);
        step("R3", 0, 0, 0, 0, 4, 1, 0, 0);

        // R4: legacy play inside the fetch window behaves like steering.
        step("R4", 1, 1, 1, 27, 2, 0, 1, 8'h61);
        step("R4", 1, 1, 0, 27, 2, 0, 0, 0);
        step("R4", 1, 1, 1, 26, 8, 1, 0, 0);
        step("R4", 0, 1, 0, 0, 13, 1, 0, 0);

        // R5 and R6: legacy play outside the window locks the processor out.
        step("R5", 1, 1, 0, 4, 2, 1, 0, 0);
        step("R6", 1, 1, 0, 4, 2, 0, 1, 8'h00);
        step("R6", 1, 1, 0, 5, 11, 0, 1, 8'h12);
        step("R6", 0, 1, 0, 4, 2, 1, 0, 0);
        step("R6", 0, 1, 0, 4, 11, 1, 0, 0);
        step("R5", 1, 1, 0, 30, 0, 1, 1, 8'h44);
        step("R5", 0, 1, 0, 30, 15, 1, 0, 0);

        // R8: read data holds with no read strobe, even across writes.
        step("R8", 0, 0, 0, 0, 6, 0, 1, 8'hBB);
        step("R8", 1, 0, 0, 12, 6, 0, 1, 8'hCC);
        step("R8", 1, 1, 0, 12, 6, 0, 0, 0);

        // R9: simultaneous read and write on one byte returns the old value.
        step("R9", 0, 0, 0, 0, 7, 1, 1, 8'h5F);
        step("R9", 0, 0, 0, 0, 7, 1, 0, 0);
        step("R9", 1, 0, 0, 17, 0, 1, 1, 8'hE2);
        step("R9", 1, 0, 0, 17, 0, 1, 0, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule